// File: doc/BRIEF.md
# Composite Sync Timing Decoder

This block turns a one-bit, active-low composite sync signal into a set of timing strobes. The signal is already sliced to logic levels and comes from a standard-definition source with either 525 or 625 lines. The strobes are a fixed-width horizontal pulse, an active-low back-porch gate, a single vertical pulse per field, a field-parity flag and a loss-of-sync flag. All timing is counted in cycles of a free-running sampling clock, and every interval is a parameter. The defaults assume a 27 MHz clock and a 64 µs line.

The input is a level, not a data stream. It is sampled on every clock edge, so the block has no valid/ready handshake and cannot apply back-pressure. The source has no way to be stalled, and each output is a plain registered level.

Inside the field blanking interval, falling edges that come at half-line spacing are rejected by a minimum-interval rule. Short equalising pulses are ignored by a low-width rule. A broad pulse produces one vertical strobe, either at its first serration or after a fallback delay. A lockout then stops the rest of the blanking group from producing another one. Field parity is judged from where the first broad pulse falls inside the line.

Top module: `csync_timing_decoder`

## Requirements
- R1: The input passes through a 2-flop synchroniser and a glitch filter. A low or high run shorter than GLITCH_CYC clock cycles has no effect on any output. A run that is kept is seen by the outputs 6 clock cycles after it begins at `csync_n`.
- R2: A falling edge of `csync_n` that is accepted makes `hsync` rise 6 cycles later. `hsync` then stays high for exactly HS_W cycles.
- R3: A falling edge is accepted only when at least LINE_CYC*3/4 cycles have passed since the previous accepted falling edge, with the input edges counted in input cycles. The first edge after reset is always accepted. A rejected edge produces no `hsync` pulse.
- R4: The rising edge that ends an accepted sync-low period drives `bporch_n` low 6 cycles later, for exactly BP_W cycles. The rising edge of a rejected pulse does not drive it.
- R5: A low period that lasts no more than BROAD_MIN cycles never produces a `vsync` pulse.
- R6: Take a low period longer than BROAD_MIN cycles that ends within VDEF cycles of its start. If it is outside the lockout, `vsync` rises 6 cycles after the rising edge that ends it, and stays high for exactly VS_W cycles.
- R7: Take a broad low period that is still low VDEF cycles after its falling edge, so that no serration has come. If it is outside the lockout, `vsync` rises VDEF+6 cycles after that falling edge.
- R8: For LINE_CYC*LOCK_LINES cycles after a `vsync` rise, no broad pulse can start another `vsync` pulse.
- R9: When `vsync` rises, `odd_field` is loaded. It takes 0 if the broad pulse's falling edge came between LINE_CYC/4 cycles (included) and LINE_CYC*3/4 cycles (excluded) after the last accepted edge, and 1 in every other case. It changes at no other time.
- R10: `no_signal` rises NOSIG_CYC+6 cycles after the last accepted falling edge when no further edge is accepted in that time. It falls 6 cycles after the next accepted falling edge.
- R11: While `rst_n` is low, the outputs are `hsync`=0, `bporch_n`=1, `vsync`=0, `odd_field`=0 and `no_signal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| hsync | output | 1 | Horizontal sync pulse, active high |
| bporch_n | output | 1 | Back-porch gate, active low |
| vsync | output | 1 | Vertical sync pulse, active high |
| odd_field | output | 1 | High during an odd field |
| no_signal | output | 1 | High after a long period with no accepted sync |

## Verification
A wrong acceptance decision shows at `hsync` six cycles after the offending edge, as a pulse that is extra or missing. The back-porch gate shows the same fault as a missing or extra low pulse at the end of that sync. A corrupted low-width or lockout count shows within one field, as a vertical pulse that is misplaced, doubled or absent. A wrong phase capture shows as an inverted `odd_field` at that same vertical pulse. The bench predicts each of these events from the timing rules alone. It compares every event time and pulse width, so a single shifted edge is caught.

// File: rtl/csd_pkg.sv
package csd_pkg;
  // Filtered view of the sync input: settled level plus one-cycle edge strobes.
  typedef struct packed {
    logic level;
    logic fall;
    logic rise;
  } csd_edge_t;
endpackage

// File: rtl/csd_input_cond.sv
module csd_input_cond
  import csd_pkg::*;
#(
  parameter int GLITCH_CYC = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din_n,
  output csd_edge_t ev
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam logic [GW-1:0] RUN_LAST = GW'(GLITCH_CYC - 1);

  logic [1:0]    sync_q;
  logic [GW-1:0] run_q;
  logic          lvl_q, fall_q, rise_q;
  logic          flip;

  // A new level is taken once it has disagreed for GLITCH_CYC samples in a row.
  assign flip = (sync_q[1] != lvl_q) && (run_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      lvl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din_n};
      if ((sync_q[1] == lvl_q) || flip) run_q <= '0;
      else                              run_q <= run_q + 1'b1;
      if (flip) lvl_q <= sync_q[1];
      fall_q <= flip & lvl_q;
      rise_q <= flip & ~lvl_q;
    end
  end

  assign ev.level = lvl_q;
  assign ev.fall  = fall_q;
  assign ev.rise  = rise_q;
endmodule

// File: rtl/csd_mono.sv
module csd_mono #(
  parameter int CW    = 16,
  parameter int WIDTH = 135
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (trig) begin
      pulse  <= 1'b1;
      left_q <= LAST;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      pulse  <= 1'b0;
    end
  end
endmodule

// File: rtl/csd_line_timer.sv
module csd_line_timer #(
  parameter int CW       = 16,
  parameter int LINE_CYC = 1728,
  parameter int HS_W     = 135,
  parameter int BP_W     = 162
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          rise,
  output logic          hsync,
  output logic          bporch_n,
  output logic          accept,
  output logic [CW-1:0] since_acc
);
  localparam logic [CW-1:0] REJ_C = CW'(LINE_CYC * 3 / 4);

  logic [CW-1:0] since_q;
  logic          gate_q;
  logic          bp_pulse;

  // Saturated at reset so the first edge is always taken.
  assign accept    = fall && (since_q >= REJ_C);
  assign since_acc = since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '1;
      gate_q  <= 1'b0;
    end else begin
      if (accept)             since_q <= CW'(1);
      else if (since_q != '1) since_q <= since_q + 1'b1;
      if (accept)    gate_q <= 1'b1;
      else if (rise) gate_q <= 1'b0;
    end
  end

  csd_mono #(.CW(CW), .WIDTH(HS_W)) u_hs_mono (
    .clk(clk), .rst_n(rst_n), .trig(accept), .pulse(hsync)
  );

  csd_mono #(.CW(CW), .WIDTH(BP_W)) u_bp_mono (
    .clk(clk), .rst_n(rst_n), .trig(rise && gate_q), .pulse(bp_pulse)
  );

  assign bporch_n = ~bp_pulse;
endmodule

// File: rtl/csd_field_detect.sv
module csd_field_detect
  import csd_pkg::*;
#(
  parameter int CW         = 16,
  parameter int LINE_CYC   = 1728,
  parameter int BROAD_MIN  = 405,
  parameter int VDEF       = 810,
  parameter int VS_W       = 5184,
  parameter int LOCK_LINES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  csd_edge_t     ev,
  input  logic [CW-1:0] since_acc,
  output logic          vsync,
  output logic          odd_field
);
  localparam logic [CW-1:0] BMIN_C = CW'(BROAD_MIN);
  localparam logic [CW-1:0] VDEF_C = CW'(VDEF);
  localparam logic [CW-1:0] LOCK_C = CW'(LINE_CYC * LOCK_LINES);
  localparam logic [CW-1:0] PH_LO  = CW'(LINE_CYC / 4);
  localparam logic [CW-1:0] PH_HI  = CW'(LINE_CYC * 3 / 4);

  logic [CW-1:0] low_q, ph_q, lock_q;
  logic          pend_q, odd_q, fire, mid;

  assign fire = pend_q && (ev.rise || (!ev.level && low_q == VDEF_C));
  assign mid  = (ph_q >= PH_LO) && (ph_q < PH_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      ph_q   <= '0;
      lock_q <= '0;
      pend_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      if (ev.fall)                       low_q <= CW'(1);
      else if (!ev.level && low_q != '1) low_q <= low_q + 1'b1;
      if (ev.fall) ph_q <= since_acc;
      if (ev.fall || ev.rise || fire)
        pend_q <= 1'b0;
      else if (!ev.level && low_q == BMIN_C && lock_q == '0)
        pend_q <= 1'b1;
      if (fire)               lock_q <= LOCK_C;
      else if (lock_q != '0)  lock_q <= lock_q - 1'b1;
      if (fire) odd_q <= ~mid;
    end
  end

  assign odd_field = odd_q;

  csd_mono #(.CW(CW), .WIDTH(VS_W)) u_vs_mono (
    .clk(clk), .rst_n(rst_n), .trig(fire), .pulse(vsync)
  );
endmodule

// File: rtl/csync_timing_decoder.sv
module csync_timing_decoder
  import csd_pkg::*;
#(
  parameter int CW         = 16,
  parameter int LINE_CYC   = 1728,
  parameter int GLITCH_CYC = 3,
  parameter int HS_W       = 135,
  parameter int BP_W       = 162,
  parameter int BROAD_MIN  = 405,
  parameter int VDEF       = 810,
  parameter int VS_W       = 5184,
  parameter int LOCK_LINES = 25,
  parameter int NOSIG_CYC  = 16200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic hsync,
  output logic bporch_n,
  output logic vsync,
  output logic odd_field,
  output logic no_signal
);
  localparam logic [CW-1:0] NS_LAST = CW'(NOSIG_CYC - 1);

  csd_edge_t     ev;
  logic          accept;
  logic [CW-1:0] since_acc;
  logic [CW-1:0] idle_q;
  logic          nosig_q;

  csd_input_cond #(.GLITCH_CYC(GLITCH_CYC)) u_in (
    .clk(clk), .rst_n(rst_n), .din_n(csync_n), .ev(ev)
  );

  csd_line_timer #(.CW(CW), .LINE_CYC(LINE_CYC), .HS_W(HS_W), .BP_W(BP_W)) u_line (
    .clk(clk), .rst_n(rst_n), .fall(ev.fall), .rise(ev.rise),
    .hsync(hsync), .bporch_n(bporch_n), .accept(accept), .since_acc(since_acc)
  );

  csd_field_detect #(
    .CW(CW), .LINE_CYC(LINE_CYC), .BROAD_MIN(BROAD_MIN), .VDEF(VDEF),
    .VS_W(VS_W), .LOCK_LINES(LOCK_LINES)
  ) u_field (
    .clk(clk), .rst_n(rst_n), .ev(ev), .since_acc(since_acc),
    .vsync(vsync), .odd_field(odd_field)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      nosig_q <= 1'b0;
    end else if (accept) begin
      idle_q  <= '0;
      nosig_q <= 1'b0;
    end else begin
      if (idle_q == NS_LAST) nosig_q <= 1'b1;
      if (idle_q != '1)      idle_q  <= idle_q + 1'b1;
    end
  end

  assign no_signal = nosig_q;
endmodule

// File: rtl/csd_timing_chk.sv
module csd_timing_chk #(
  parameter int CW         = 16,
  parameter int LINE_CYC   = 1728,
  parameter int HS_W       = 135,
  parameter int BP_W       = 162,
  parameter int VS_W       = 5184,
  parameter int LOCK_LINES = 25,
  parameter int NOSIG_CYC  = 16200
) (
  input logic clk,
  input logic rst_n,
  input logic hsync,
  input logic bporch_n,
  input logic vsync,
  input logic odd_field,
  input logic no_signal
);
  localparam logic [CW-1:0] HS_C   = CW'(HS_W);
  localparam logic [CW-1:0] BP_C   = CW'(BP_W);
  localparam logic [CW-1:0] VS_C   = CW'(VS_W);
  localparam logic [CW-1:0] REJ_C  = CW'(LINE_CYC * 3 / 4);
  localparam logic [CW-1:0] LOCK_C = CW'(LINE_CYC * LOCK_LINES);
  localparam logic [CW-1:0] NS_C   = CW'(NOSIG_CYC - 1);

  logic [CW-1:0] hrun, brun, vrun, hgap, vgap, idle;
  logic          hprev, vprev, hseen, vseen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrun <= '0; brun <= '0; vrun <= '0; hgap <= '0; vgap <= '0; idle <= '0;
      hprev <= 1'b0; vprev <= 1'b0; hseen <= 1'b0; vseen <= 1'b0;
    end else begin
      hprev <= hsync;
      vprev <= vsync;
      hrun  <= hsync     ? hrun + 1'b1 : '0;
      brun  <= !bporch_n ? brun + 1'b1 : '0;
      vrun  <= vsync     ? vrun + 1'b1 : '0;
      if (hsync && !hprev) begin hgap <= CW'(1); hseen <= 1'b1; idle <= '0; end
      else begin
        if (hgap != '1) hgap <= hgap + 1'b1;
        if (idle != '1) idle <= idle + 1'b1;
      end
      if (vsync && !vprev) begin vgap <= CW'(1); vseen <= 1'b1; end
      else if (vgap != '1) vgap <= vgap + 1'b1;
    end
  end

  // R2
  hs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> hrun == HS_C);
  // R3
  hs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (!hseen || hgap >= REJ_C));
  // R4
  bp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bporch_n) |-> brun == BP_C);
  // R6
  vs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> vrun == VS_C);
  // R8
  vs_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (!vseen || vgap >= LOCK_C));
  // R9
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(odd_field) |-> $rose(vsync));
  // R10
  nosig_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_signal) |-> idle >= NS_C);
  // R10
  nosig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> !no_signal);
endmodule

bind csync_timing_decoder csd_timing_chk #(
  .CW(CW), .LINE_CYC(LINE_CYC), .HS_W(HS_W), .BP_W(BP_W), .VS_W(VS_W),
  .LOCK_LINES(LOCK_LINES), .NOSIG_CYC(NOSIG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .bporch_n(bporch_n),
  .vsync(vsync), .odd_field(odd_field), .no_signal(no_signal)
);

// File: tb/test_csync_timing_decoder.sv
module test_csync_timing_decoder;
  localparam int LINE = 128, GL = 3, HSW = 10, BPW = 12, BMIN = 20, VDEF = 70;
  localparam int VSW = 16, LOCKL = 4, NOSIG = 1000, LAT = 6;
  localparam int REJ = LINE * 3 / 4, LOCK = LINE * LOCKL;

  logic clk = 1'b0, rst_n = 1'b0, csync_n = 1'b1;
  logic hsync, bporch_n, vsync, odd_field, no_signal;

  csync_timing_decoder #(
    .CW(16), .LINE_CYC(LINE), .GLITCH_CYC(GL), .HS_W(HSW), .BP_W(BPW),
    .BROAD_MIN(BMIN), .VDEF(VDEF), .VS_W(VSW), .LOCK_LINES(LOCKL), .NOSIG_CYC(NOSIG)
  ) i_csync_timing_decoder (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .hsync(hsync), .bporch_n(bporch_n),
    .vsync(vsync), .odd_field(odd_field), .no_signal(no_signal)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int exp_h[$], exp_bp[$], exp_v[$], exp_odd[$];
  int obs_h[$], obs_bp[$], obs_v[$], obs_odd[$];
  int last_acc = -1000000;
  int lock_ok = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected events for one kept low period starting at input cycle c.
  task automatic model_fall(int c, int low);
    int ph = c - last_acc;
    if (ph >= REJ) begin
      exp_h.push_back(c + LAT);
      exp_bp.push_back(c + low + LAT);
      last_acc = c;
    end
    if (low > BMIN && (c + LAT + BMIN) >= lock_ok) begin
      int f = (low <= VDEF) ? (c + low + LAT) : (c + LAT + VDEF);
      exp_v.push_back(f);
      exp_odd.push_back((ph >= LINE / 4 && ph < REJ) ? 0 : 1);
      lock_ok = f + LOCK + 1;
    end
  endtask

  task automatic pulse(int low, int high);
    int c;
    @(negedge clk);
    c = cyc;
    csync_n = 1'b0;
    if (low >= GL) model_fall(c, low);
    repeat (low) @(negedge clk);
    csync_n = 1'b1;
    repeat (high - 1) @(negedge clk);
  endtask

  task automatic field(bit odd, bit serr);
    repeat (4) pulse(10, LINE - 10);
    if (odd) begin pulse(10, LINE - 10); repeat (6) pulse(5, LINE / 2 - 5); end
    else     begin pulse(10, LINE / 2 - 10); repeat (4) pulse(5, LINE / 2 - 5); end
    if (serr) repeat (5) pulse(54, 10);
    else begin pulse(200, 10); pulse(54, 10); end
    repeat (5) pulse(5, LINE / 2 - 5);
    repeat (6) pulse(10, LINE - 10);
  endtask

  // Monitor: event times and pulse widths, sampled on the falling clock edge.
  int hs0, bp0, vs0;
  logic hs_d = 1'b0, bp_d = 1'b1, vs_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hsync && !hs_d) begin obs_h.push_back(cyc); hs0 = cyc; end
      if (!hsync && hs_d) check("R2 hsync width", cyc - hs0, HSW);
      if (!bporch_n && bp_d) begin obs_bp.push_back(cyc); bp0 = cyc; end
      if (bporch_n && !bp_d) check("R4 bporch width", cyc - bp0, BPW);
      if (vsync && !vs_d) begin obs_v.push_back(cyc); obs_odd.push_back(int'(odd_field)); vs0 = cyc; end
      if (!vsync && vs_d) check("R6 vsync width", cyc - vs0, VSW);
    end
    hs_d = hsync; bp_d = bporch_n; vs_d = vsync;
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 hsync", int'(hsync), 0);
    check("R11 bporch_n", int'(bporch_n), 1);
    check("R11 vsync", int'(vsync), 0);
    check("R11 odd_field", int'(odd_field), 0);
    check("R11 no_signal", int'(no_signal), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4: random line pulses, glitches and half-line extras
    for (int i = 0; i < 24; i++) begin
      int low = 6 + int'($urandom % 9);
      int sel = int'($urandom % 4);
      if (sel == 0) begin
        int g  = 1 + int'($urandom % 2);
        int h1 = 20 + int'($urandom % 40);
        pulse(low, h1);
        pulse(g, LINE - low - h1 - g);
      end else if (sel == 1) begin
        int low2 = 4 + int'($urandom % 8);
        pulse(low, LINE / 2 - low);
        pulse(low2, LINE / 2 - low2);
      end else begin
        pulse(low, LINE - low);
      end
    end
    // R3 boundary: exactly REJ accepted, REJ-1 rejected
    pulse(10, REJ - 10);
    pulse(10, REJ - 11);
    pulse(10, LINE - 10);
    // R5 boundary: a low of exactly BROAD_MIN cycles
    pulse(BMIN, LINE - BMIN);
    pulse(10, LINE - 10);
    repeat (8) @(negedge clk);
    check("R5 no vsync from narrow lows", obs_v.size(), 0);

    // R6 R9 odd field with serrations
    field(1'b1, 1'b1);
    check("R9 odd after line-start broad", int'(odd_field), 1);
    // R6 R9 even field with serrations
    field(1'b0, 1'b1);
    check("R9 even after mid-line broad", int'(odd_field), 0);
    // R7 R8 missing serration plus a close second broad
    field(1'b1, 1'b0);
    check("R7 odd after default-delay field", int'(odd_field), 1);
    // random field mix
    for (int i = 0; i < 3; i++) field(1'($urandom % 2), 1'($urandom % 2));
    check("R10 no_signal low while active", int'(no_signal), 0);

    // R10 timeout and clear
    while (cyc < last_acc + LAT + NOSIG - 1) @(negedge clk);
    check("R10 no_signal before timeout", int'(no_signal), 0);
    @(negedge clk);
    check("R10 no_signal at timeout", int'(no_signal), 1);
    pulse(10, LINE - 10);
    check("R10 no_signal cleared", int'(no_signal), 0);
    repeat (40) @(negedge clk);

    // Event-list comparison
    check("R2 R3 hsync count", obs_h.size(), exp_h.size());
    for (int i = 0; i < exp_h.size() && i < obs_h.size(); i++)
      check("R1 R2 R3 hsync time", obs_h[i], exp_h[i]);
    check("R4 bporch count", obs_bp.size(), exp_bp.size());
    for (int i = 0; i < exp_bp.size() && i < obs_bp.size(); i++)
      check("R4 bporch time", obs_bp[i], exp_bp[i]);
    check("R6 R7 R8 vsync count", obs_v.size(), exp_v.size());
    for (int i = 0; i < exp_v.size() && i < obs_v.size(); i++) begin
      check("R6 R7 R8 vsync time", obs_v[i], exp_v[i]);
      check("R9 parity", obs_odd[i], exp_odd[i]);
    end
    finish_run();
  end
endmodule